// File: doc/BRIEF.md
# TDM Daisy-Chain Audio Slot Receiver

This block listens to a shared time-division multiplexed audio bus on which several identical receivers sit one after another along a daisy chain. The bus runs on a bit clock, which is also the block's clock, and carries a frame sync pulse plus one serial data line. Each frame is a sequence of 32-bit slots. Slot ownership is not fixed by an index. Instead a token travels down the chain. A receiver that sees the token at the start of a slot takes that slot and the following `CHANNELS-1` slots. It captures one 24-bit sample from each slot it owns.

While its last owned slot is on the bus, the receiver raises its chain output, so the next receiver knows that the slot after it is its own. A receiver whose channel enable is low owns nothing and passes the chain input straight to the chain output in the same cycle. Captured samples leave through a valid/ready stream that carries the sample word and its channel number.

Back-pressure rules: a beat stays valid until it is accepted. The stream has a single beat of storage. If a newer sample completes while a beat is still pending, the newer sample replaces it. A consumer that keeps ready high sees a one-cycle valid pulse per sample.

Top module: `tdm_chain_rx`

## Requirements
- R1: The cycle in which `fsync` is high is bit 0 of slot 0. Bit positions then count 0 to 31 and wrap, so each slot is 32 cycles long. Before the first `fsync` after reset, no slot is claimed and no sample is produced.
- R2: Data is sampled on the rising clock edge, most significant bit first. `out_data` holds slot bits 31 down to 8, which are the first 24 bits received. Slot bits 7 down to 0 have no effect on the output.
- R3: Suppose `chan_en` is high and `chain_in` is high in the bit-0 cycle of a slot. If this receiver has not yet claimed a run in the current frame, it owns that slot and the next `CHANNELS-1` slots. These carry channel numbers 0, 1, and so on, reported on `out_chan`.
- R4: A receiver claims at most one run per frame. Once a run has been claimed, `chain_in` is ignored until the next `fsync`, so holding `chain_in` high yields exactly `CHANNELS` samples per frame.
- R5: With `chan_en` high, `chain_out` rises in the cycle after the bit-0 cycle of the last owned slot. It stays high until the cycle after the bit-0 cycle of the following slot, and is low at all other times.
- R6: With `chan_en` low, `chain_out` equals `chain_in` in the same cycle, and no sample is produced.
- R7: `out_valid` rises in the cycle after bit 31 of an owned slot. It stays high until a cycle where `out_ready` is high. A newer sample replaces a pending one.
- R8: During and right after reset, `out_valid` is low. `chain_out` is also low, unless the block is disabled and `chain_in` is high.
- R9: A run does not continue across a frame sync. An owned slot remaining when `fsync` arrives is not claimed unless a fresh token is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, high for the bit-0 cycle of slot 0 |
| sdata | input | 1 | Serial audio data, MSB first |
| chain_in | input | 1 | Ownership token from the upstream receiver |
| chan_en | input | 1 | Channel enable; low means no active channel |
| chain_out | output | 1 | Token to the downstream receiver |
| out_valid | output | 1 | Sample beat valid |
| out_ready | input | 1 | Sample beat accepted when high together with valid |
| out_data | output | SAMPLE_BITS | Captured sample |
| out_chan | output | CH_W | Channel number of the captured sample |

## Verification
Several properties are checked on every cycle. The bit position must advance steadily between frame syncs, and a beat may appear only right after a slot's last bit while enabled. A pending beat must hold under back-pressure, and the chain output may change only at a slot's bit-0 boundary. A frame must never yield more than `CHANNELS` captures. Only the bench scenarios can show that the right slots are claimed and that their upper 24 bits arrive intact with the right channel numbers. The same is true of the replacement under back-pressure, the truncation of a run at a frame sync, and the same-cycle pass-through when disabled.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
  localparam int unsigned DEF_SLOT_BITS   = 32;
  localparam int unsigned DEF_SAMPLE_BITS = 24;
  localparam int unsigned DEF_CHANNELS    = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
  import tdm_chain_pkg::*;
#(
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  localparam int unsigned IW = idx_width(SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  output logic [IW-1:0] bit_idx,
  output logic          live
);
  localparam logic [IW-1:0] LAST_BIT = IW'(SLOT_BITS - 1);

  logic [IW-1:0] cnt_q;
  logic          synced_q;

  assign bit_idx = fsync ? '0 : cnt_q;
  assign live    = synced_q | fsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
    end else if (live) begin
      synced_q <= 1'b1;
      cnt_q    <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_chain_owner.sv
module tdm_chain_owner
  import tdm_chain_pkg::*;
#(
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  parameter int unsigned CHANNELS  = DEF_CHANNELS,
  localparam int unsigned IW   = idx_width(SLOT_BITS),
  localparam int unsigned CH_W = idx_width(CHANNELS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fsync,
  input  logic            live,
  input  logic [IW-1:0]   bit_idx,
  input  logic            chan_en,
  input  logic            chain_in,
  output logic            own,
  output logic [CH_W-1:0] ch,
  output logic            chain_out
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(CHANNELS - 1);

  logic            own_q, done_q, last_q;
  logic [CH_W-1:0] ch_q;
  logic            slot_start, cont, claim, done_eff;
  logic            next_is_last;

  assign slot_start = live && (bit_idx == '0);
  assign done_eff   = done_q && !fsync;
  assign cont       = !fsync && own_q && (ch_q != LAST_CH);
  assign claim      = !cont && chan_en && !done_eff && chain_in;

  generate
    if (CHANNELS == 1) begin : g_single
      assign next_is_last = claim;
    end else begin : g_multi
      assign next_is_last = (cont && (ch_q + 1'b1 == LAST_CH)) || (claim && (LAST_CH == '0));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= 1'b0;
      ch_q   <= '0;
      done_q <= 1'b0;
      last_q <= 1'b0;
    end else if (slot_start) begin
      own_q  <= cont || claim;
      ch_q   <= cont ? ch_q + 1'b1 : '0;
      done_q <= done_eff || claim;
      last_q <= next_is_last;
    end
  end

  assign own       = own_q;
  assign ch        = ch_q;
  assign chain_out = chan_en ? last_q : chain_in;
endmodule

// File: rtl/tdm_sample_capture.sv
module tdm_sample_capture
  import tdm_chain_pkg::*;
#(
  parameter int unsigned SLOT_BITS   = DEF_SLOT_BITS,
  parameter int unsigned SAMPLE_BITS = DEF_SAMPLE_BITS,
  parameter int unsigned CH_W        = 1,
  localparam int unsigned IW = idx_width(SLOT_BITS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sdata,
  input  logic                   live,
  input  logic [IW-1:0]          bit_idx,
  input  logic                   take_en,
  input  logic [CH_W-1:0]        ch,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [SAMPLE_BITS-1:0] out_data,
  output logic [CH_W-1:0]        out_chan,
  output logic                   take
);
  localparam logic [IW-1:0] LAST_BIT = IW'(SLOT_BITS - 1);

  logic [SLOT_BITS-2:0] shreg;
  logic [SLOT_BITS-1:0] word;

  assign word = {shreg, sdata};
  assign take = live && (bit_idx == LAST_BIT) && take_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SLOT_BITS-3:0], sdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= word[SLOT_BITS-1 -: SAMPLE_BITS];
      out_chan  <= ch;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_chain_rx.sv
module tdm_chain_rx
  import tdm_chain_pkg::*;
#(
  parameter int unsigned SLOT_BITS   = DEF_SLOT_BITS,
  parameter int unsigned SAMPLE_BITS = DEF_SAMPLE_BITS,
  parameter int unsigned CHANNELS    = DEF_CHANNELS,
  localparam int unsigned IW   = idx_width(SLOT_BITS),
  localparam int unsigned CH_W = idx_width(CHANNELS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fsync,
  input  logic                   sdata,
  input  logic                   chain_in,
  input  logic                   chan_en,
  output logic                   chain_out,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [SAMPLE_BITS-1:0] out_data,
  output logic [CH_W-1:0]        out_chan
);
  logic [IW-1:0]   bit_idx;
  logic            slot_live;
  logic            slot_own;
  logic [CH_W-1:0] slot_ch;
  logic            sample_take;

  tdm_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .bit_idx(bit_idx), .live(slot_live)
  );

  tdm_chain_owner #(.SLOT_BITS(SLOT_BITS), .CHANNELS(CHANNELS)) u_owner (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .live(slot_live), .bit_idx(bit_idx),
    .chan_en(chan_en), .chain_in(chain_in), .own(slot_own), .ch(slot_ch),
    .chain_out(chain_out)
  );

  tdm_sample_capture #(.SLOT_BITS(SLOT_BITS), .SAMPLE_BITS(SAMPLE_BITS), .CH_W(CH_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .live(slot_live), .bit_idx(bit_idx),
    .take_en(slot_own && chan_en), .ch(slot_ch), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan), .take(sample_take)
  );
endmodule

// File: rtl/tdm_chain_rx_chk.sv
module tdm_chain_rx_chk
  import tdm_chain_pkg::*;
#(
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  parameter int unsigned CHANNELS  = DEF_CHANNELS,
  localparam int unsigned IW = idx_width(SLOT_BITS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fsync,
  input logic          chan_en,
  input logic          chain_out,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] idx,
  input logic          live,
  input logic          emit
);
  localparam logic [IW-1:0] LAST_BIT = IW'(SLOT_BITS - 1);

  logic [7:0] emits_in_frame;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     emits_in_frame <= '0;
    else if (fsync) emits_in_frame <= '0;
    else if (emit)  emits_in_frame <= emits_in_frame + 1'b1;
  end

  assert_bit_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(live) && !fsync |->
      idx == (($past(idx) == LAST_BIT) ? '0 : $past(idx) + 1'b1));

  assert_emit_at_slot_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(idx) == LAST_BIT && $past(live));

  assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_token_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && $past(chan_en) && $rose(chain_out) |-> $past(idx) == '0 && $past(live));

  assert_token_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && $past(chan_en) && $fell(chain_out) |-> $past(idx) == '0 && $past(live));

  assert_silent_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(chan_en));

  assert_one_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> emits_in_frame < 8'(CHANNELS));
endmodule

bind tdm_chain_rx tdm_chain_rx_chk #(.SLOT_BITS(SLOT_BITS), .CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .chan_en(chan_en), .chain_out(chain_out),
  .out_valid(out_valid), .out_ready(out_ready), .idx(bit_idx), .live(slot_live),
  .emit(sample_take)
);

// File: tb/sim_tdm_chain_rx.sv
`timescale 1ns/1ps
module sim_tdm_chain_rx;
  localparam int NCH = 2;
  localparam int SLOTS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0, sdata = 1'b0, cin = 1'b0, en = 1'b1, rdy = 1'b1;
  logic chain_out, out_valid;
  logic [23:0] out_data;
  logic [0:0]  out_chan;

  int n_checks = 0, n_fail = 0;
  int frame_no = 0;
  logic [24:0] got[$];

  always #2.5 clk = ~clk;

  tdm_chain_rx u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata), .chain_in(cin),
    .chan_en(en), .chain_out(chain_out), .out_valid(out_valid), .out_ready(rdy),
    .out_data(out_data), .out_chan(out_chan)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] slot_word(input int fr, input int s);
    return {8'(fr * 3 + 1), 8'(s * 7), 8'hC3, 8'h5A};
  endfunction

  // behavioural reference model, advanced on every rising edge
  bit m_sync, m_own, m_done, m_cq, e_valid;
  int m_cnt, m_ch;
  logic [31:0] m_sh;
  logic [23:0] e_data;
  int e_chan;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_own = 0; m_done = 0; m_cq = 0; e_valid = 0;
      m_cnt = 0; m_ch = 0; m_sh = '0; e_data = '0; e_chan = 0;
    end else begin
      if (m_sync || fsync) begin
        int idx;
        logic [31:0] w;
        idx = fsync ? 0 : m_cnt;
        m_sync = 1;
        if (idx == 0) begin
          bit d;
          d = fsync ? 0 : m_done;
          if (!fsync && m_own && m_ch < NCH - 1) m_ch = m_ch + 1;
          else if (en && !d && cin) begin m_own = 1; m_ch = 0; d = 1; end
          else m_own = 0;
          m_done = d;
          m_cq = m_own && (m_ch == NCH - 1);
        end
        w = {m_sh[30:0], sdata};
        if (idx == 31 && m_own && en) begin
          e_valid = 1; e_data = w[31:8]; e_chan = m_ch;
        end else if (rdy) e_valid = 0;
        m_cnt = (idx + 1) % 32;
      end else if (rdy) e_valid = 0;
      m_sh = {m_sh[30:0], sdata};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(chain_out === (en ? m_cq : cin), en ? "R5 chain_out" : "R6 chain_out pass-through",
            chain_out, en ? m_cq : cin);
      check(out_valid === e_valid, "R7 out_valid", out_valid, e_valid);
      if (e_valid) begin
        check(out_data === e_data, "R2 out_data", out_data, e_data);
        check(out_chan === 1'(e_chan), "R3 out_chan", out_chan, e_chan);
      end
      if (out_valid && rdy) got.push_back({out_chan, out_data});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      fsync = 0; sdata = 0; cin = 0;
    end
  endtask

  // claim < 0: no token; hold: token held high all frame
  task automatic frame(input int claim, input bit hold);
    frame_no++;
    for (int s = 0; s < SLOTS; s++) begin
      for (int b = 0; b < 32; b++) begin
        logic [31:0] w;
        w = slot_word(frame_no, s);
        @(posedge clk); #1;
        fsync = (s == 0 && b == 0);
        sdata = w[31 - b];
        cin = hold || (claim >= 0 && ((s == claim && b == 0) ||
                                      (claim > 0 && s == claim - 1 && b >= 1)));
      end
    end
  endtask

  task automatic expect_got(input string tag, input logic [24:0] exp[$]);
    check(got.size() == exp.size(), {tag, " sample count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check(got[i] === exp[i], {tag, " sample value"}, got[i], exp[i]);
    got.delete();
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [24:0] exp[$];
    repeat (4) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R8 reset out_valid", out_valid, 0);
    check(chain_out === 1'b0, "R8 reset chain_out", chain_out, 0);
    rst_n = 1;

    // R1: token present before any frame sync
    for (int i = 0; i < 40; i++) begin @(posedge clk); #1; cin = 1; end
    idle(2);
    exp.delete(); expect_got("R1 no capture before sync", exp);

    // R2 R3: token at slot 2, low bits nonzero
    frame(2, 0); idle(3);
    exp = '{{1'b0, slot_word(frame_no, 2)[31:8]}, {1'b1, slot_word(frame_no, 3)[31:8]}};
    expect_got("R3 claimed run", exp);

    // R4: token held high the whole frame
    frame(-1, 1); idle(3);
    exp = '{{1'b0, slot_word(frame_no, 0)[31:8]}, {1'b1, slot_word(frame_no, 1)[31:8]}};
    expect_got("R4 single run per frame", exp);

    // R9: run cut by the next frame sync
    frame(SLOTS - 1, 0);
    exp = '{{1'b0, slot_word(frame_no, SLOTS - 1)[31:8]}};
    frame(-1, 0); idle(3);
    expect_got("R9 run ends at sync", exp);

    // R7: back-pressure, newer sample replaces pending one
    rdy = 0;
    frame(0, 0); idle(4);
    check(out_valid === 1'b1, "R7 held under back-pressure", out_valid, 1);
    exp = '{{1'b1, slot_word(frame_no, 1)[31:8]}};
    rdy = 1; idle(3);
    expect_got("R7 replacement", exp);

    // R6: disabled receiver forwards the token, captures nothing
    en = 0;
    frame(3, 0); idle(3);
    exp.delete(); expect_got("R6 disabled", exp);
    en = 1;
    frame(5, 0); idle(3);
    exp = '{{1'b0, slot_word(frame_no, 5)[31:8]}, {1'b1, slot_word(frame_no, 6)[31:8]}};
    expect_got("R3 after re-enable", exp);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule